// File: doc/BRIEF.md
# Real-Time Clock Status Register with Alarm Interrupt

This block is the status register of a real-time clock, together with the interrupt logic and the power-up defaults of the neighbouring control register. It keeps three flags. The first is an update-pending flag. It warns software that a time-data update is about to happen. The second is a low-battery flag, fed by two supply comparators. The third is an alarm interrupt flag, set by the alarm comparison logic. The interrupt pin is the alarm flag gated by an enable bit in the control register.

Software reaches the block over a simple single-cycle register bus. A read returns data combinationally in the same cycle. Any read or write that targets an alarm register address clears the alarm flag as a side effect. The block only decodes those addresses; it does not store the alarm registers. An external timer supplies periodic ticks. Every `UPD_PERIOD` ticks the block issues an update strobe. The update-pending flag is raised `UPD_LEAD` ticks ahead of that strobe.

Top module: `rtc_status_reg`

## Requirements
- R1: After reset, the status byte reads 0x00, the control byte reads 0xB0 and `irq_out` is 0. In the control byte, bit 7 (oscillator off) and bits 5:4 (watchdog select) reset to 1. Bit 6 (write protect) and bits 3:2 (alarm select) reset to 0.
- R2: Status byte layout: bit 7 is the update-pending flag, bit 6 is the low-battery flag and bit 0 is the alarm flag. Bits 5:1 always read 0.
- R3: A cycle with `alarm_match` high sets the alarm flag at the next clock edge.
- R4: `irq_out` is 1 exactly when the alarm flag is 1 and control bit 1 (alarm interrupt enable) is 1.
- R5: A read or write at any alarm address (0x8, 0x9, 0xA) clears the alarm flag at the next edge. Accesses to any other address leave the flag unchanged.
- R6: When `alarm_match` and an alarm-address access occur in the same cycle, the alarm flag ends up set.
- R7: `lb_below_low` sets the low-battery flag and `lb_above_high` clears it. With neither input active, the flag holds. With both active, the set wins.
- R8: Each `upd_tick` advances a counter modulo `UPD_PERIOD` (default 8). The update-pending flag reads 1 while the count is at least `UPD_PERIOD-UPD_LEAD` (default 6). The tick that wraps the counter causes `upd_strobe` to pulse for the one following cycle, and the flag is 0 in that cycle.
- R9: Writes to the status address (0xF) are ignored.
- R10: The control byte at address 0xE is read/write, except that bit 0 always reads 0.
- R11: Reads of any address other than 0xE and 0xF, including the alarm addresses, return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alarm_match | input | 1 | Pulse from the alarm comparators |
| lb_below_low | input | 1 | Backup supply below the low threshold |
| lb_above_high | input | 1 | Backup supply above the high threshold |
| upd_tick | input | 1 | Update-scheduling timer tick |
| bus_sel | input | 1 | Register access in this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| irq_out | output | 1 | Alarm interrupt pin |
| upd_strobe | output | 1 | One-cycle time-data update pulse |

## Verification
The hardest case to reach is a collision: an alarm match and an alarm-register access landing on the same edge. The stimulus drives both in one bus cycle, then reads the status byte. A second hard case is a status byte with several flags set at once. To reach it, the bench first steps the tick counter into its pre-update window, then fires the battery and alarm inputs together. Finally, it carries the counter through the wrap so that the strobe coincides with the flag falling.

// File: rtl/rtc_stat_pkg.sv
package rtc_stat_pkg;

    localparam int DATA_W = 8;

    typedef struct packed {
        logic       upd;
        logic       lowbat;
        logic [4:0] rsvd;
        logic       irqf;
    } stat_t;

    typedef struct packed {
        logic       osc_off;
        logic       wprot;
        logic [1:0] wd_sel;
        logic [1:0] alm_sel;
        logic       alm_ie;
        logic       rsvd;
    } ctrl_t;

    localparam ctrl_t CTRL_RESET = '{osc_off: 1'b1, wprot: 1'b0, wd_sel: 2'b11,
                                     alm_sel: 2'b00, alm_ie: 1'b0, rsvd: 1'b0};

    function automatic ctrl_t ctrl_from_byte(input logic [DATA_W-1:0] b);
        ctrl_t r;
        r      = ctrl_t'(b);
        r.rsvd = 1'b0;
        return r;
    endfunction

    function automatic stat_t stat_pack(input logic upd, input logic lowbat, input logic irqf);
        stat_t s;
        s.upd    = upd;
        s.lowbat = lowbat;
        s.rsvd   = '0;
        s.irqf   = irqf;
        return s;
    endfunction

endpackage

// File: rtl/rtc_addr_decode.sv
module rtc_addr_decode #(
    parameter int ADDR_W    = 4,
    parameter int ALM_BASE  = 8,
    parameter int ALM_CNT   = 3,
    parameter int CTRL_ADDR = 14,
    parameter int STAT_ADDR = 15
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit_alarm,
    output logic              hit_ctrl,
    output logic              hit_stat
);
    logic [ALM_CNT-1:0] alm_hits;

    for (genvar i = 0; i < ALM_CNT; i++) begin : g_alm
        assign alm_hits[i] = (addr == ADDR_W'(ALM_BASE + i));
    end

    assign hit_alarm = |alm_hits;
    assign hit_ctrl  = (addr == ADDR_W'(CTRL_ADDR));
    assign hit_stat  = (addr == ADDR_W'(STAT_ADDR));
endmodule

// File: rtl/rtc_upd_sched.sv
module rtc_upd_sched #(
    parameter int PERIOD = 8,
    parameter int LEAD   = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    output logic upd_flag,
    output logic upd_strobe
);
    localparam int CNT_W = (PERIOD > 2) ? $clog2(PERIOD) : 1;
    localparam logic [CNT_W-1:0] LAST    = CNT_W'(PERIOD - 1);
    localparam logic [CNT_W-1:0] FLAG_AT = CNT_W'(PERIOD - LEAD);

    if (LEAD < 1 || LEAD >= PERIOD) begin : g_bad_params
        $error("rtc_upd_sched: LEAD must lie in 1..PERIOD-1");
    end

    logic [CNT_W-1:0] cnt_q;
    logic             strobe_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q    <= '0;
            strobe_q <= 1'b0;
        end else begin
            strobe_q <= tick && (cnt_q == LAST);
            if (tick) begin
                cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
            end
        end
    end

    assign upd_flag   = (cnt_q >= FLAG_AT);
    assign upd_strobe = strobe_q;

    assert_strobe_after_flag_R8: assert property (@(posedge clk) disable iff (rst)
        upd_strobe |-> $past(upd_flag));
    assert_flag_low_on_strobe_R8: assert property (@(posedge clk) disable iff (rst)
        upd_strobe |-> !upd_flag);
    assert_cnt_range_R8: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LAST);
    assert_no_tick_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(upd_flag) && !upd_strobe);
endmodule

// File: rtl/rtc_flag_bits.sv
module rtc_flag_bits (
    input  logic clk,
    input  logic rst,
    input  logic alarm_match,
    input  logic alarm_access,
    input  logic lb_set,
    input  logic lb_clr,
    output logic irqf,
    output logic lowbat
);
    logic irqf_q;
    logic lowbat_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            irqf_q   <= 1'b0;
            lowbat_q <= 1'b0;
        end else begin
            if (alarm_match)       irqf_q <= 1'b1;
            else if (alarm_access) irqf_q <= 1'b0;
            if (lb_set)            lowbat_q <= 1'b1;
            else if (lb_clr)       lowbat_q <= 1'b0;
        end
    end

    assign irqf   = irqf_q;
    assign lowbat = lowbat_q;

    assert_match_sets_R3: assert property (@(posedge clk) disable iff (rst)
        alarm_match |=> irqf);
    assert_access_clears_R5: assert property (@(posedge clk) disable iff (rst)
        alarm_access && !alarm_match |=> !irqf);
    assert_lb_set_wins_R7: assert property (@(posedge clk) disable iff (rst)
        lb_set |=> lowbat);
    assert_lb_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !lb_set && !lb_clr |=> $stable(lowbat));
endmodule

// File: rtl/rtc_status_reg.sv
module rtc_status_reg
    import rtc_stat_pkg::*;
#(
    parameter int ADDR_W     = 4,
    parameter int ALM_BASE   = 8,
    parameter int ALM_CNT    = 3,
    parameter int CTRL_ADDR  = 14,
    parameter int STAT_ADDR  = 15,
    parameter int UPD_PERIOD = 8,
    parameter int UPD_LEAD   = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              alarm_match,
    input  logic              lb_below_low,
    input  logic              lb_above_high,
    input  logic              upd_tick,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output logic              irq_out,
    output logic              upd_strobe
);
    logic  hit_alarm, hit_ctrl, hit_stat;
    logic  upd_flag, irqf, lowbat;
    ctrl_t ctrl_q;
    stat_t stat;

    rtc_addr_decode #(
        .ADDR_W(ADDR_W), .ALM_BASE(ALM_BASE), .ALM_CNT(ALM_CNT),
        .CTRL_ADDR(CTRL_ADDR), .STAT_ADDR(STAT_ADDR)
    ) i_dec (
        .addr(bus_addr), .hit_alarm(hit_alarm), .hit_ctrl(hit_ctrl), .hit_stat(hit_stat)
    );

    rtc_upd_sched #(.PERIOD(UPD_PERIOD), .LEAD(UPD_LEAD)) i_sched (
        .clk(clk), .rst(rst), .tick(upd_tick),
        .upd_flag(upd_flag), .upd_strobe(upd_strobe)
    );

    rtc_flag_bits i_flags (
        .clk(clk), .rst(rst),
        .alarm_match(alarm_match), .alarm_access(bus_sel && hit_alarm),
        .lb_set(lb_below_low), .lb_clr(lb_above_high),
        .irqf(irqf), .lowbat(lowbat)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= CTRL_RESET;
        end else if (bus_sel && bus_we && hit_ctrl) begin
            ctrl_q <= ctrl_from_byte(bus_wdata);
        end
    end

    assign stat = stat_pack(upd_flag, lowbat, irqf);

    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_we) begin
            if (hit_stat)      bus_rdata = stat;
            else if (hit_ctrl) bus_rdata = ctrl_q;
        end
    end

    assign irq_out = irqf && ctrl_q.alm_ie;

    assert_stat_write_ignored_R9: assert property (@(posedge clk) disable iff (rst)
        bus_sel && bus_we && hit_stat && !alarm_match && !lb_below_low
        && !lb_above_high && !upd_tick |=> $stable(stat));
    assert_irq_follows_enable_R4: assert property (@(posedge clk) disable iff (rst)
        !ctrl_q.alm_ie |-> !irq_out);
    assert_ctrl_bit0_zero_R10: assert property (@(posedge clk) disable iff (rst)
        ctrl_q.rsvd == 1'b0);
endmodule

// File: tb/test_rtc_status_reg.sv
`timescale 1ns/100ps
module test_rtc_status_reg;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       alarm_match = 0, lb_below_low = 0, lb_above_high = 0, upd_tick = 0;
    logic       bus_sel = 0, bus_we = 0;
    logic [3:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       irq_out, upd_strobe;

    int errors = 0;
    int checks = 0;
    bit done   = 0;

    typedef struct {
        int         kind;
        logic [7:0] exp;
        string      tag;
    } item_t;
    item_t q[$];
    event  push_ev;

    always #2 clk = ~clk;

    rtc_status_reg i_rtc_status_reg (
        .clk(clk), .rst(rst), .alarm_match(alarm_match), .lb_below_low(lb_below_low),
        .lb_above_high(lb_above_high), .upd_tick(upd_tick), .bus_sel(bus_sel),
        .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_out(irq_out), .upd_strobe(upd_strobe)
    );

    // Monitor: compares ports against the expected items in the scoreboard.
    initial begin
        forever begin
            @(push_ev);
            while (q.size() != 0) begin
                item_t it;
                logic [7:0] act;
                it  = q.pop_front();
                act = (it.kind == 0) ? bus_rdata :
                      (it.kind == 1) ? {7'b0, irq_out} : {7'b0, upd_strobe};
                checks++;
                if (act !== it.exp) begin
                    errors++;
                    $display("FAIL %s kind=%0d: actual=%h expected=%h", it.tag, it.kind, act, it.exp);
                end
            end
        end
    end

    task automatic drive(input logic sel, input logic we, input logic [3:0] a,
                         input logic [7:0] d, input logic m, input logic ls,
                         input logic lc, input logic t);
        @(negedge clk);
        bus_sel = sel; bus_we = we; bus_addr = a; bus_wdata = d;
        alarm_match = m; lb_below_low = ls; lb_above_high = lc; upd_tick = t;
    endtask

    task automatic expect_port(input int kind, input logic [7:0] exp, input string tag);
        #0.2;
        q.push_back('{kind: kind, exp: exp, tag: tag});
        -> push_ev;
    endtask

    task automatic nop();                          drive(0, 0, 4'h0, 8'h00, 0, 0, 0, 0); endtask
    task automatic wr(input logic [3:0] a, input logic [7:0] d); drive(1, 1, a, d, 0, 0, 0, 0); endtask
    task automatic match();                        drive(0, 0, 4'h0, 8'h00, 1, 0, 0, 0); endtask
    task automatic tick();                         drive(0, 0, 4'h0, 8'h00, 0, 0, 0, 1); endtask
    task automatic rd(input logic [3:0] a, input logic [7:0] exp, input string tag);
        drive(1, 0, a, 8'h00, 0, 0, 0, 0);
        expect_port(0, exp, tag);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // Reset state and read map
        rd(4'hF, 8'h00, "R1"); expect_port(1, 8'h00, "R1");
        rd(4'hE, 8'hB0, "R1");
        rd(4'h3, 8'h00, "R11"); rd(4'h0, 8'h00, "R11");
        // Control register
        wr(4'hE, 8'hFF); rd(4'hE, 8'hFE, "R10");
        // Alarm set and interrupt gating
        match(); nop(); expect_port(1, 8'h01, "R4");
        rd(4'hF, 8'h01, "R3");
        wr(4'hE, 8'hFC); rd(4'hE, 8'hFC, "R10"); expect_port(1, 8'h00, "R4");
        rd(4'hF, 8'h01, "R4");
        wr(4'hE, 8'hFE); nop(); expect_port(1, 8'h01, "R4");
        // Clear by alarm access only
        wr(4'h2, 8'h55); rd(4'hF, 8'h01, "R5");
        rd(4'hB, 8'h00, "R11"); rd(4'hF, 8'h01, "R5");
        rd(4'h7, 8'h00, "R11"); rd(4'hF, 8'h01, "R5");
        rd(4'h9, 8'h00, "R11"); rd(4'hF, 8'h00, "R5"); expect_port(1, 8'h00, "R5");
        match(); wr(4'hA, 8'h12); rd(4'hF, 8'h00, "R5");
        // Collision: set wins
        match(); drive(1, 0, 4'h8, 8'h00, 1, 0, 0, 0);
        rd(4'hF, 8'h01, "R6"); expect_port(1, 8'h01, "R6");
        // Status writes ignored
        wr(4'hF, 8'hFF); rd(4'hF, 8'h01, "R9");
        wr(4'hF, 8'h00); rd(4'hF, 8'h01, "R9");
        wr(4'h8, 8'h00); rd(4'hF, 8'h00, "R5");
        // Low battery
        drive(0, 0, 4'h0, 8'h00, 0, 1, 0, 0); rd(4'hF, 8'h40, "R7");
        nop(); nop(); rd(4'hF, 8'h40, "R7");
        drive(0, 0, 4'h0, 8'h00, 0, 0, 1, 0); rd(4'hF, 8'h00, "R7");
        drive(0, 0, 4'h0, 8'h00, 0, 1, 1, 0); rd(4'hF, 8'h40, "R7");
        drive(0, 0, 4'h0, 8'h00, 0, 0, 1, 0); rd(4'hF, 8'h00, "R7");
        // Update scheduling
        for (int i = 0; i < 5; i++) tick();
        rd(4'hF, 8'h00, "R8"); expect_port(2, 8'h00, "R8");
        tick(); rd(4'hF, 8'h80, "R8");
        tick(); rd(4'hF, 8'h80, "R8"); expect_port(2, 8'h00, "R8");
        tick(); rd(4'hF, 8'h00, "R8"); expect_port(2, 8'h01, "R8");
        nop(); expect_port(2, 8'h00, "R8");
        // All flags together, then wrap with flags held
        for (int i = 0; i < 6; i++) tick();
        drive(0, 0, 4'h0, 8'h00, 1, 1, 0, 0);
        rd(4'hF, 8'hC1, "R2");
        tick(); tick();
        rd(4'hF, 8'h41, "R2"); expect_port(2, 8'h01, "R8");

        nop();
        #0.5;
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule